// File: doc/BRIEF.md
# FIFO watermark interrupt unit

This block raises interrupts for a serial peripheral based on FIFO fill levels. It holds a transmit FIFO and a receive FIFO, each eight entries deep. Data enters and leaves each FIFO through simple push and pop strobes. Software programs a 3-bit level for each direction through a 32-bit register port.

On every clock the unit compares each FIFO's occupancy with its programmed level:
- The transmit side flags "needs refill" while its occupancy is strictly below its level.
- The receive side flags "needs draining" while its occupancy is strictly above its level.

Both flags are registered. They can be read back, but software cannot set or clear them; only FIFO traffic or a change of level moves them. A 2-bit enable register selects which flags reach the single interrupt output, which is also registered.

Top module: `wm_irq_unit`

## Requirements
- R1: After reset every mapped register reads 0, `irq` is 0, both FIFOs report empty and neither reports full.
- R2: Offset 0x50 holds the transmit level in bits [2:0] and offset 0x54 holds the receive level in bits [2:0]. Both are read/write, and bits [31:3] read as zero whatever was written.
- R3: Offset 0x70 holds the enables: bit 0 for transmit, bit 1 for receive. It is read/write, and bits [31:2] read as zero.
- R4: Bit 0 of the pending register at 0x74 equals (transmit occupancy < transmit level). It takes the new value one clock after the push, pop or level write that changes the comparison.
- R5: Bit 1 of the pending register at 0x74 equals (receive occupancy > receive level), with the same one-clock timing.
- R6: Writes to 0x74 change nothing; the pending bits read back unchanged.
- R7: The pending bits do not depend on the enables. `irq` is the OR of (pending AND enable) over both sources, registered, so it follows one clock after the change that causes it.
- R8: A push into a full FIFO (8 entries) and a pop from an empty FIFO are ignored and leave the occupancy unchanged. The full and empty outputs are decoded from occupancy 8 and occupancy 0.
- R9: Reads of any offset other than 0x50, 0x54, 0x70 and 0x74 return 0, and writes to such offsets change no register.
- R10: Each FIFO returns its accepted entries in push order. The pop data output shows the oldest entry and is valid whenever the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_push | input | 1 | Push strobe, transmit FIFO |
| tx_push_data | input | 8 | Data to push, transmit FIFO |
| tx_full | output | 1 | Transmit FIFO holds 8 entries |
| tx_pop | input | 1 | Pop strobe, transmit FIFO |
| tx_pop_data | output | 8 | Oldest transmit entry |
| tx_empty | output | 1 | Transmit FIFO holds 0 entries |
| rx_push | input | 1 | Push strobe, receive FIFO |
| rx_push_data | input | 8 | Data to push, receive FIFO |
| rx_full | output | 1 | Receive FIFO holds 8 entries |
| rx_pop | input | 1 | Pop strobe, receive FIFO |
| rx_pop_data | output | 8 | Oldest receive entry |
| rx_empty | output | 1 | Receive FIFO holds 0 entries |
| irq | output | 1 | Combined watermark interrupt |

## Verification
The hardest cases to observe are the ignored push into a full FIFO and the ignored pop from an empty one. Occupancy is not a port, so a corrupted counter can only show up indirectly.

The stimulus exposes these cases in two ways. It fills a FIFO, pushes once more, and then checks that exactly eight pops drain it with the original data in order. It also sets the receive level to 0 before popping the empty receive FIFO. With that level, any counter wrap would raise the receive pending bit at once.

Walking occupancy across every level boundary, with the enables both off and on, covers both strict comparisons and the interrupt gating.

// File: rtl/wm_irq_pkg.sv
`timescale 1ns/1ps
package wm_irq_pkg;
    parameter int REG_W      = 32;
    parameter int ADDR_W     = 8;
    parameter int DATA_W     = 8;
    parameter int FIFO_DEPTH = 8;
    parameter int MARK_W     = 3;

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int NUM_CH = 2;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

    localparam logic [ADDR_W-1:0] OFS_TX_LEVEL = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_RX_LEVEL = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_PENDING  = 8'h74;

    typedef logic [MARK_W-1:0] mark_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // bit 0 = transmit, bit 1 = receive
    typedef struct packed {
        logic rx;
        logic tx;
    } wm_pair_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TX_LEVEL,
        SEL_RX_LEVEL,
        SEL_ENABLE,
        SEL_PENDING
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        case (a)
            OFS_TX_LEVEL: s = SEL_TX_LEVEL;
            OFS_RX_LEVEL: s = SEL_RX_LEVEL;
            OFS_ENABLE:   s = SEL_ENABLE;
            OFS_PENDING:  s = SEL_PENDING;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic below_level(input cnt_t c, input mark_t m);
        return c < cnt_t'(m);
    endfunction

    function automatic logic above_level(input cnt_t c, input mark_t m);
        return c > cnt_t'(m);
    endfunction
endpackage

// File: rtl/wm_fifo.sv
`timescale 1ns/1ps
module wm_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign pop_data = store[rd_ptr];
    assign count   = count_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/wm_regs.sv
`timescale 1ns/1ps
module wm_regs
    import wm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  wm_pair_t          pending,
    output logic [REG_W-1:0]  rdata,
    output mark_t             tx_level,
    output mark_t             rx_level,
    output wm_pair_t          enable
);
    reg_sel_t sel;
    logic     unused_wdata_hi;

    assign sel             = decode_addr(addr);
    assign unused_wdata_hi = ^wdata[REG_W-1:MARK_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_level <= '0;
            rx_level <= '0;
            enable   <= '0;
        end else if (we) begin
            case (sel)
                SEL_TX_LEVEL: tx_level <= wdata[MARK_W-1:0];
                SEL_RX_LEVEL: rx_level <= wdata[MARK_W-1:0];
                SEL_ENABLE:   enable   <= wm_pair_t'(wdata[1:0]);
                default:      ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_TX_LEVEL: rdata[MARK_W-1:0] = tx_level;
            SEL_RX_LEVEL: rdata[MARK_W-1:0] = rx_level;
            SEL_ENABLE:   rdata[1:0]        = enable;
            SEL_PENDING:  rdata[1:0]        = pending;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/wm_irq_eval.sv
`timescale 1ns/1ps
module wm_irq_eval
    import wm_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_t     tx_count,
    input  cnt_t     rx_count,
    input  mark_t    tx_level,
    input  mark_t    rx_level,
    input  wm_pair_t enable,
    output wm_pair_t pending,
    output logic     irq
);
    wm_pair_t pend_d;

    always_comb begin
        pend_d.tx = below_level(tx_count, tx_level);
        pend_d.rx = above_level(rx_count, rx_level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            irq     <= 1'b0;
        end else begin
            pending <= pend_d;
            irq     <= |(pend_d & enable);
        end
    end
endmodule

// File: rtl/wm_irq_unit.sv
`timescale 1ns/1ps
module wm_irq_unit
    import wm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    output logic              tx_full,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic              tx_empty,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    output logic              rx_full,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic              rx_empty,
    output logic              irq
);
    logic [NUM_CH-1:0] push_v, pop_v, full_v, empty_v;
    logic [DATA_W-1:0] push_d [NUM_CH];
    logic [DATA_W-1:0] pop_d  [NUM_CH];
    cnt_t              cnt_v  [NUM_CH];

    cnt_t     tx_cnt, rx_cnt;
    mark_t    tx_level_q, rx_level_q;
    wm_pair_t en_q, pend_q;

    assign push_v = {rx_push, tx_push};
    assign pop_v  = {rx_pop, tx_pop};
    assign push_d[CH_TX] = tx_push_data;
    assign push_d[CH_RX] = rx_push_data;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fifo
        wm_fifo #(
            .DEPTH  (FIFO_DEPTH),
            .DATA_W (DATA_W)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (push_v[ch]),
            .push_data (push_d[ch]),
            .pop       (pop_v[ch]),
            .pop_data  (pop_d[ch]),
            .full      (full_v[ch]),
            .empty     (empty_v[ch]),
            .count     (cnt_v[ch])
        );
    end

    assign tx_cnt      = cnt_v[CH_TX];
    assign rx_cnt      = cnt_v[CH_RX];
    assign tx_full     = full_v[CH_TX];
    assign rx_full     = full_v[CH_RX];
    assign tx_empty    = empty_v[CH_TX];
    assign rx_empty    = empty_v[CH_RX];
    assign tx_pop_data = pop_d[CH_TX];
    assign rx_pop_data = pop_d[CH_RX];

    wm_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .pending  (pend_q),
        .rdata    (reg_rdata),
        .tx_level (tx_level_q),
        .rx_level (rx_level_q),
        .enable   (en_q)
    );

    wm_irq_eval u_eval (
        .clk      (clk),
        .rst      (rst),
        .tx_count (tx_cnt),
        .rx_count (rx_cnt),
        .tx_level (tx_level_q),
        .rx_level (rx_level_q),
        .enable   (en_q),
        .pending  (pend_q),
        .irq      (irq)
    );
endmodule

// File: rtl/wm_irq_unit_chk.sv
`timescale 1ns/1ps
module wm_irq_unit_chk
    import wm_irq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     tx_push,
    input logic     tx_pop,
    input logic     tx_full,
    input logic     rx_push,
    input logic     rx_pop,
    input logic     rx_empty,
    input cnt_t     tx_cnt,
    input cnt_t     rx_cnt,
    input mark_t    tx_level_q,
    input mark_t    rx_level_q,
    input wm_pair_t en_q,
    input wm_pair_t pend_q,
    input logic     irq
);
    AST_TX_PENDING_LEVEL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q.tx == $past(tx_cnt < cnt_t'(tx_level_q)))); // R4
    AST_RX_PENDING_LEVEL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q.rx == $past(rx_cnt > cnt_t'(rx_level_q)))); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(((tx_cnt < cnt_t'(tx_level_q)) && en_q.tx) ||
                               ((rx_cnt > cnt_t'(rx_level_q)) && en_q.rx)))); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= cnt_t'(FIFO_DEPTH)) && (rx_cnt <= cnt_t'(FIFO_DEPTH))); // R8
    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_push && !tx_pop) |=> (tx_cnt == $past(tx_cnt))); // R8
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && rx_pop && !rx_push) |=> (rx_cnt == $past(rx_cnt))); // R8
endmodule

bind wm_irq_unit wm_irq_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_push    (tx_push),
    .tx_pop     (tx_pop),
    .tx_full    (tx_full),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_empty   (rx_empty),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .tx_level_q (tx_level_q),
    .rx_level_q (rx_level_q),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .irq        (irq)
);

// File: tb/wm_irq_unit_tb.sv
`timescale 1ns/1ps
module wm_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]  tx_push_data = '0, rx_push_data = '0;
    logic [7:0]  tx_pop_data, rx_pop_data;
    logic        tx_full, tx_empty, rx_full, rx_empty, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int tx_cnt_m = 0, rx_cnt_m = 0;
    int tx_lvl_m = 0, rx_lvl_m = 0;
    logic [1:0] en_m = 2'b00;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wm_irq_unit dut_i (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_full(tx_full),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_full(rx_full),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_empty(rx_empty),
        .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares popped data against the scoreboard queues (R10)
    always @(posedge clk) begin
        if (!rst && tx_pop && !tx_empty) begin
            if (tx_q.size() == 0) chk("R10", "tx pop with empty scoreboard", 32'(tx_pop_data), 32'hFFFF_FFFF);
            else chk("R10", "tx pop data", 32'(tx_pop_data), 32'(tx_q.pop_front()));
        end
        if (!rst && rx_pop && !rx_empty) begin
            if (rx_q.size() == 0) chk("R10", "rx pop with empty scoreboard", 32'(rx_pop_data), 32'hFFFF_FFFF);
            else chk("R10", "rx pop data", 32'(rx_pop_data), 32'(rx_q.pop_front()));
        end
    end

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push_tx(input logic [7:0] d);
        @(negedge clk);
        tx_push = 1'b1; tx_push_data = d;
        if (tx_cnt_m < DEPTH) begin tx_q.push_back(d); tx_cnt_m++; end
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        tx_pop = 1'b1;
        if (tx_cnt_m > 0) tx_cnt_m--;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_push_data = d;
        if (rx_cnt_m < DEPTH) begin rx_q.push_back(d); rx_cnt_m++; end
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk);
        rx_pop = 1'b1;
        if (rx_cnt_m > 0) rx_cnt_m--;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    // Reads pending, irq, full and empty against the model
    task automatic status(input string req);
        logic [31:0] v;
        logic [1:0]  exp_p;
        exp_p = {rx_cnt_m > rx_lvl_m, tx_cnt_m < tx_lvl_m};
        reg_rd(8'h74, v);
        chk(req, "pending", v, {30'd0, exp_p});
        chk(req, "irq", {31'd0, irq}, {31'd0, |(exp_p & en_m)});
        chk(req, "flags", {28'd0, tx_full, tx_empty, rx_full, rx_empty},
            {28'd0, tx_cnt_m == DEPTH, tx_cnt_m == 0, rx_cnt_m == DEPTH, rx_cnt_m == 0});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        reg_rd(8'h50, v); chk("R1", "tx level reset", v, 0);
        reg_rd(8'h54, v); chk("R1", "rx level reset", v, 0);
        reg_rd(8'h70, v); chk("R1", "enable reset", v, 0);
        reg_rd(8'h74, v); chk("R1", "pending reset", v, 0);
        chk("R1", "irq reset", {31'd0, irq}, 0);
        chk("R1", "empty/full reset", {28'd0, tx_full, tx_empty, rx_full, rx_empty}, 32'h5);

        // R2, R3: field widths
        reg_wr(8'h50, 32'hFFFF_FFFD); tx_lvl_m = 5;
        reg_rd(8'h50, v); chk("R2", "tx level readback", v, 5);
        reg_wr(8'h54, 32'hFFFF_FFFA); rx_lvl_m = 2;
        reg_rd(8'h54, v); chk("R2", "rx level readback", v, 2);
        reg_wr(8'h70, 32'hFFFF_FFFF);
        reg_rd(8'h70, v); chk("R3", "enable readback", v, 3);
        reg_wr(8'h70, 32'h0);
        reg_rd(8'h70, v); chk("R3", "enable cleared", v, 0);
        status("R4"); // tx pending from level write alone, irq masked (R7)

        // R4: walk tx occupancy across its level, enables off
        for (int i = 0; i < DEPTH; i++) begin
            push_tx(8'hA0 + 8'(i));
            status("R4");
        end
        push_tx(8'hEE); // R8: ignored, FIFO full
        status("R8");

        // R7: enable tx, drain across boundary
        reg_wr(8'h70, 32'h1); en_m = 2'b01;
        status("R7");
        for (int i = 0; i < DEPTH; i++) begin
            pop_tx();
            status("R7");
        end
        pop_tx(); // R8: ignored, FIFO empty
        status("R8");
        push_tx(8'h55);
        pop_tx();
        status("R10");

        // R5: rx side with rx enable only
        reg_wr(8'h70, 32'h2); en_m = 2'b10;
        for (int i = 0; i < DEPTH; i++) begin
            push_rx(8'h30 + 8'(i));
            status("R5");
        end
        push_rx(8'hEF);
        status("R8");
        for (int i = 0; i < DEPTH; i++) begin
            pop_rx();
            status("R5");
        end
        reg_wr(8'h54, 32'h0); rx_lvl_m = 0;
        pop_rx(); // underflow would make count > 0
        status("R8");
        push_rx(8'h77);
        status("R5");

        // R6: pending is read-only
        reg_wr(8'h70, 32'h3); en_m = 2'b11;
        reg_wr(8'h74, 32'h0);
        status("R6");
        reg_wr(8'h74, 32'hFFFF_FFFC);
        status("R6");

        // R9: unmapped offsets
        reg_wr(8'h58, 32'hFFFF_FFFF);
        reg_rd(8'h58, v); chk("R9", "unmapped read 0x58", v, 0);
        reg_wr(8'h00, 32'h7);
        reg_rd(8'h40, v); chk("R9", "unmapped read 0x40", v, 0);
        reg_rd(8'h7C, v); chk("R9", "unmapped read 0x7C", v, 0);
        reg_rd(8'h50, v); chk("R9", "tx level intact", v, 5);
        reg_rd(8'h54, v); chk("R9", "rx level intact", v, 0);
        reg_rd(8'h70, v); chk("R9", "enable intact", v, 3);
        pop_rx();
        status("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule